// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block sits behind a network receive path and moves one incoming frame at a time into host memory through a ring of receive descriptors. Frame bytes arrive as a valid/ready byte stream with an end-of-frame marker. When the first byte shows up and receive is enabled, the engine reads the three leading words of the descriptor at the current ring position: a control/status word with an ownership bit, a size word, and the buffer address. It then stores the frame into that buffer and, on success, rewrites the control/status word with the delivered length.

Once a frame has been delivered, the ring position either steps to the next descriptor or returns to the ring base when the descriptor carries a wrap mark. The engine pulses status-event outputs that an interrupt block can latch. It also keeps running counts of delivered frames by address class (individual, group, all-ones) and a byte total. Address filtering and checksum verification happen elsewhere.

Memory is reached through a single-beat master port. A request is held until granted, and read data is returned in the grant cycle. Descriptors are `STRIDE` bytes apart. Word 0 of a descriptor is control/status, word 1 holds the buffer size in its low half, and word 2 is the word-aligned buffer address.

Top module: `rx_desc_writeback`

## Requirements
- R1: While `rx_enable` is low and no frame is in progress, `in_ready` stays low and no memory request is issued, so the frame is refused and left waiting on the stream.
- R2: A frame begins with three reads at `cur_desc`, `cur_desc+4` and `cur_desc+8`. `in_ready` is low while these reads and the final status write are outstanding.
- R3: Frame bytes are packed little-endian (byte k of the frame goes to lane k mod 4) into 32-bit words. These words are written to consecutive word addresses starting at the buffer address. The last partial word carries byte enables set only on its low, filled lanes, so memory beyond the frame is untouched.
- R4: A frame of fewer than 12 bytes pulses `evt_ri` and `evt_nis` together. It causes no status write, leaves `cur_desc` unchanged and does not move any counter.
- R5: When bit 31 of descriptor word 0 is clear, the frame is consumed without any buffer write or status write. `evt_ru` and `evt_ais` pulse together, and `cur_desc` and the counters stay unchanged.
- R6: On delivery, descriptor word 0 at `cur_desc` is overwritten with ((length + 4) << 16) | 0x300. Bit 31 of that value is zero, which returns the descriptor to the host.
- R7: After delivery, `cur_desc` becomes `ring_base` if bit 15 of descriptor word 1 is set; otherwise it advances by `STRIDE` (32).
- R8: On delivery, `evt_ri` and `evt_nis` pulse, `cnt_frames` increments by one and `cnt_bytes` grows by length + 4.
- R9: A delivered frame whose first byte has bit 0 clear counts in `cnt_ucast`. One whose first six bytes are all 0xFF counts in `cnt_bcast`. Any other frame counts in `cnt_mcast`.
- R10: A `base_load` pulse copies `ring_base` into `cur_desc` on the next clock edge. Reset clears `cur_desc`, all counters, `in_ready` and `mem_req`.
- R11: A memory request that is not granted is held on the next cycle with the same address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receive enable |
| base_load | input | 1 | Load pulse for the ring base |
| ring_base | input | AW | Ring base address |
| cur_desc | output | AW | Current descriptor address |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the final one of the frame |
| in_ready | output | 1 | Engine accepts the byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| evt_ri | output | 1 | Receive-complete event pulse |
| evt_nis | output | 1 | Normal summary event pulse |
| evt_ru | output | 1 | Descriptor-unavailable event pulse |
| evt_ais | output | 1 | Abnormal summary event pulse |
| cnt_frames | output | CNT_W | Delivered frames |
| cnt_ucast | output | CNT_W | Delivered individual-address frames |
| cnt_mcast | output | CNT_W | Delivered group-address frames |
| cnt_bcast | output | CNT_W | Delivered all-ones-address frames |
| cnt_bytes | output | CNT_W | Delivered bytes including four per frame |

## Verification
The hardest case to reach is the final partial-word write being stalled by a withheld grant while the frame has already ended. The same applies to a refused descriptor or a wrap mark landing on exactly that frame. The stimulus reaches these by granting memory at random about three cycles in four. It also draws frame lengths, ownership, wrap marks and address classes at random, and it presets every buffer with a fill pattern so that a stray byte enable shows up as a changed byte past the frame end.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DATA,
    ST_FINISH,
    ST_WB
  } wb_state_t;

  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned WRAP_BIT  = 15;

  // completed status word: length including four trailer bytes in the
  // upper half, first/last markers in the low half, ownership cleared
  function automatic logic [31:0] done_word(input logic [15:0] frame_len);
    logic [15:0] total;
    total = frame_len + 16'd4;
    return {total, 16'h0300};
  endfunction

  // a byte mask is well formed when it is a run of ones from lane 0
  function automatic logic low_run(input logic [3:0] be);
    return (be != 4'd0) && (((be + 4'd1) & be) == 4'd0);
  endfunction

endpackage

// File: rtl/rxwb_packer.sv
module rxwb_packer import rxwb_pkg::*; #(
  parameter int unsigned IW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic [7:0]    byte_in,
  input  logic          last,
  input  logic          wr_done,
  output logic          pend,
  output logic [31:0]   wdata,
  output logic [3:0]    wbe,
  output logic [IW-1:0] widx
);
  localparam int unsigned LANE_W = $clog2(BUS_BYTES);

  logic [LANE_W-1:0] lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane  <= '0;
      wbe   <= '0;
      wdata <= '0;
      pend  <= 1'b0;
      widx  <= '0;
    end else if (clear) begin
      lane <= '0;
      wbe  <= '0;
      pend <= 1'b0;
      widx <= '0;
    end else if (wr_done) begin
      pend <= 1'b0;
      wbe  <= '0;
      widx <= widx + 1'b1;
    end else if (take) begin
      wdata[lane*8 +: 8] <= byte_in;
      wbe[lane]          <= 1'b1;
      if (lane == LANE_W'(BUS_BYTES - 1) || last) begin
        pend <= 1'b1;
        lane <= '0;
      end else begin
        lane <= lane + 1'b1;
      end
    end
  end

  // a pending word always starts at lane 0 and has no holes
  assert_be_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> low_run(wbe));

  // no byte may be taken while a word waits for the bus
  assert_no_take_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !wr_done && !clear) |=> $stable(wdata));

endmodule

// File: rtl/rxwb_stats.sv
module rxwb_stats #(
  parameter int unsigned LEN_W = 14,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             is_ucast,
  input  logic             is_bcast,
  input  logic [LEN_W-1:0] frame_len,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_ucast,
  output logic [CNT_W-1:0] cnt_mcast,
  output logic [CNT_W-1:0] cnt_bcast,
  output logic [CNT_W-1:0] cnt_bytes
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_frames <= '0;
      cnt_ucast  <= '0;
      cnt_mcast  <= '0;
      cnt_bcast  <= '0;
      cnt_bytes  <= '0;
    end else if (commit) begin
      cnt_frames <= cnt_frames + 1'b1;
      cnt_bytes  <= cnt_bytes + CNT_W'(frame_len) + CNT_W'(4);
      if (is_ucast)      cnt_ucast <= cnt_ucast + 1'b1;
      else if (is_bcast) cnt_bcast <= cnt_bcast + 1'b1;
      else               cnt_mcast <= cnt_mcast + 1'b1;
    end
  end

  // the three class counters partition the delivered frames
  assert_class_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ucast + cnt_mcast + cnt_bcast) == cnt_frames);

  assert_frame_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cnt_bytes != $past(cnt_bytes));

endmodule

// File: rtl/rx_desc_writeback.sv
module rx_desc_writeback import rxwb_pkg::*; #(
  parameter int unsigned AW      = 32,
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned STRIDE  = 32,
  parameter int unsigned MIN_LEN = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic             base_load,
  input  logic [AW-1:0]    ring_base,
  output logic [AW-1:0]    cur_desc,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_gnt,
  input  logic [31:0]      mem_rdata,
  output logic             evt_ri,
  output logic             evt_nis,
  output logic             evt_ru,
  output logic             evt_ais,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_ucast,
  output logic [CNT_W-1:0] cnt_mcast,
  output logic [CNT_W-1:0] cnt_bcast,
  output logic [CNT_W-1:0] cnt_bytes
);
  localparam int unsigned CLASS_BYTES = 6;

  function automatic logic [AW-1:0] next_desc(input logic [AW-1:0] cur,
                                              input logic [AW-1:0] base,
                                              input logic          wrap);
    return wrap ? base : cur + AW'(STRIDE);
  endfunction

  wb_state_t        state;
  logic [1:0]       fidx;
  logic [31:0]      ctl_q, size_q;
  logic [AW-1:0]    buf_q;
  logic [LEN_W-1:0] len_q;
  logic             uc_q, bc_q;

  // named internal events
  logic start_w, accept_w, owned_w, short_w, decide_w, commit_w, wr_done_w;
  logic pk_pend;
  logic [31:0]      pk_data;
  logic [3:0]       pk_be;
  logic [LEN_W-1:0] pk_idx;

  assign owned_w   = ctl_q[OWN_BIT];
  assign short_w   = len_q < LEN_W'(MIN_LEN);
  assign start_w   = (state == ST_IDLE) && in_valid && rx_enable;
  assign in_ready  = (state == ST_DATA) && !pk_pend;
  assign accept_w  = in_ready && in_valid;
  assign decide_w  = (state == ST_FINISH) && !pk_pend;
  assign commit_w  = (state == ST_WB) && mem_gnt;
  assign wr_done_w = pk_pend && mem_gnt &&
                     (state == ST_DATA || state == ST_FINISH);

  assign evt_ri  = (decide_w && short_w) || commit_w;
  assign evt_nis = evt_ri;
  assign evt_ru  = decide_w && !short_w && !owned_w;
  assign evt_ais = evt_ru;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_desc;
    mem_wdata = '0;
    mem_be    = '0;
    unique case (state)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_desc + AW'({fidx, 2'b00});
      end
      ST_DATA, ST_FINISH: begin
        mem_req   = pk_pend;
        mem_we    = 1'b1;
        mem_addr  = buf_q + AW'({pk_idx, 2'b00});
        mem_wdata = pk_data;
        mem_be    = pk_be;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = done_word(16'(len_q));
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      fidx   <= '0;
      ctl_q  <= '0;
      size_q <= '0;
      buf_q  <= '0;
      len_q  <= '0;
      uc_q   <= 1'b0;
      bc_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_w) begin
          state <= ST_FETCH;
          fidx  <= '0;
          len_q <= '0;
          bc_q  <= 1'b1;
        end
        ST_FETCH: if (mem_gnt) begin
          fidx <= fidx + 1'b1;
          unique case (fidx)
            2'd0:    ctl_q  <= mem_rdata;
            2'd1:    size_q <= mem_rdata;
            default: begin
              buf_q <= AW'(mem_rdata);
              state <= ST_DATA;
            end
          endcase
        end
        ST_DATA: if (accept_w) begin
          len_q <= len_q + 1'b1;
          if (len_q == '0) uc_q <= ~in_data[0];
          if (len_q < LEN_W'(CLASS_BYTES)) bc_q <= bc_q & (in_data == 8'hFF);
          if (in_last) state <= ST_FINISH;
        end
        ST_FINISH: if (decide_w) begin
          state <= (short_w || !owned_w) ? ST_IDLE : ST_WB;
        end
        ST_WB: if (mem_gnt) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_desc <= '0;
    else if (base_load) cur_desc <= ring_base;
    else if (commit_w)  cur_desc <= next_desc(cur_desc, ring_base, size_q[WRAP_BIT]);
  end

  rxwb_packer #(.IW(LEN_W)) packer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_w),
    .take    (accept_w && owned_w),
    .byte_in (in_data),
    .last    (in_last),
    .wr_done (wr_done_w),
    .pend    (pk_pend),
    .wdata   (pk_data),
    .wbe     (pk_be),
    .widx    (pk_idx)
  );

  rxwb_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W)) stats_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit_w),
    .is_ucast   (uc_q),
    .is_bcast   (bc_q),
    .frame_len  (len_q),
    .cnt_frames (cnt_frames),
    .cnt_ucast  (cnt_ucast),
    .cnt_mcast  (cnt_mcast),
    .cnt_bcast  (cnt_bcast),
    .cnt_bytes  (cnt_bytes)
  );

  assert_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !rx_enable) |=> !mem_req);

  assert_busy_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (!mem_we || state == ST_WB)) |-> !in_ready);

  assert_short_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ri && !commit_w && !base_load) |=> $stable(cur_desc) && $stable(cnt_frames));

  assert_drop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ru |-> evt_ais && !evt_ri && !mem_req);

  assert_no_buf_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !owned_w) |-> !mem_req);

  assert_ptr_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_w && !base_load) |=>
      (cur_desc == $past(ring_base) || cur_desc == $past(cur_desc) + AW'(STRIDE)));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !base_load) |=>
      mem_req && $stable(mem_addr) && $stable(mem_we));

endmodule

// File: tb/rx_desc_writeback_tb_top.sv
module rx_desc_writeback_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned CW = 32;
  localparam logic [31:0] FILL = 32'hA5A5A5A5;
  localparam int unsigned BUF  = 32'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic rx_enable = 1'b0, base_load = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic [AW-1:0] cur_desc;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic mem_req, mem_we, mem_gnt = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic evt_ri, evt_nis, evt_ru, evt_ais;
  logic [CW-1:0] cnt_frames, cnt_ucast, cnt_mcast, cnt_bcast, cnt_bytes;

  rx_desc_writeback dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .base_load(base_load),
    .ring_base(ring_base), .cur_desc(cur_desc), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .evt_ri(evt_ri), .evt_nis(evt_nis),
    .evt_ru(evt_ru), .evt_ais(evt_ais), .cnt_frames(cnt_frames),
    .cnt_ucast(cnt_ucast), .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast),
    .cnt_bytes(cnt_bytes)
  );

  // memory model: read data with the grant, writes at the edge
  logic [31:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk)
    if (mem_req && mem_gnt && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  always @(negedge clk) mem_gnt <= ($urandom % 4) != 0;

  int n_checks = 0, n_fail = 0;
  int n_ri = 0, n_nis = 0, n_ru = 0, n_ais = 0, n_req = 0;
  always @(posedge clk) begin
    if (evt_ri)  n_ri  <= n_ri + 1;
    if (evt_nis) n_nis <= n_nis + 1;
    if (evt_ru)  n_ru  <= n_ru + 1;
    if (evt_ais) n_ais <= n_ais + 1;
    if (mem_req) n_req <= n_req + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] mbyte(input int unsigned a);
    return mem[(a >> 2) & 255][8*(a % 4) +: 8];
  endfunction

  function automatic logic [31:0] exp_word(input int len);
    return ((len + 4) << 16) | 32'h300;
  endfunction

  logic [7:0] fb [0:63];

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[i]; in_last = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  logic [AW-1:0] e_ptr = '0;
  logic [CW-1:0] e_fr = 0, e_uc = 0, e_mc = 0, e_bc = 0, e_by = 0;

  task automatic frame(input int len, input int cls, input bit own, input bit wrap);
    int ev0, ri0, ru0;
    logic [AW-1:0] d;
    d = e_ptr;
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    if (cls == 0) fb[0] = fb[0] & 8'hFE;
    else if (cls == 1) begin fb[0] = fb[0] | 8'h01; fb[1] = 8'h00; end
    else for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
    mem[d[9:2]]     = own ? 32'h8000_0000 : 32'h0;
    mem[d[9:2] + 1] = {16'h0, wrap, 15'h0800};
    mem[d[9:2] + 2] = BUF;
    for (int w = 0; w < 16; w++) mem[BUF/4 + w] = FILL;
    ri0 = n_ri; ru0 = n_ru; ev0 = n_ri + n_ru;
    send(len);
    while (n_ri + n_ru == ev0) @(negedge clk);
    @(negedge clk);
    if (len < 12) begin
      check("R4 short event", 64'(n_ri - ri0), 1);
      check("R4 no writeback", mem[d[9:2]], own ? 32'h8000_0000 : 32'h0);
      check("R4 ptr kept", cur_desc, e_ptr);
    end else if (!own) begin
      check("R5 drop event", 64'(n_ru - ru0), 1);
      check("R5 no buffer write", mem[BUF/4], FILL);
      check("R5 desc kept", mem[d[9:2]], 32'h0);
      check("R5 ptr kept", cur_desc, e_ptr);
    end else begin
      e_fr++; e_by += CW'(len + 4);
      if (cls == 0) e_uc++; else if (cls == 1) e_mc++; else e_bc++;
      e_ptr = wrap ? '0 : e_ptr + 32;
      check("R6 status word", mem[d[9:2]], exp_word(len));
      check("R7 ring pointer", cur_desc, e_ptr);
      check("R8 ri event", 64'(n_ri - ri0), 1);
      for (int i = 0; i < len; i++) check("R3 buffer byte", mbyte(BUF + i), fb[i]);
      for (int i = len; i < ((len + 3) / 4) * 4; i++) check("R3 tail untouched", mbyte(BUF + i), 8'hA5);
    end
    check("R8 frames", cnt_frames, e_fr);
    check("R8 bytes", cnt_bytes, e_by);
    check("R9 ucast", cnt_ucast, e_uc);
    check("R9 mcast", cnt_mcast, e_mc);
    check("R9 bcast", cnt_bcast, e_bc);
    check("R8 nis pairs ri", n_nis, n_ri);
    check("R5 ais pairs ru", n_ais, n_ru);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < 256; w++) mem[w] = 32'h0;
    repeat (3) @(negedge clk);
    check("R10 reset ptr", cur_desc, 0);
    check("R10 reset frames", cnt_frames, 0);
    check("R10 reset ready", in_ready, 0);
    check("R10 reset req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: disabled receive leaves the frame waiting
    in_valid = 1'b1; in_data = 8'h10;
    begin
      int r0, rdy;
      r0 = n_req; rdy = 0;
      repeat (12) begin @(negedge clk); rdy += int'(in_ready); end
      check("R1 ready held low", 64'(rdy), 0);
      check("R1 no memory access", 64'(n_req - r0), 0);
    end
    in_valid = 1'b0;
    rx_enable = 1'b1;
    @(negedge clk);
    // directed corners
    frame(12, 0, 1'b1, 1'b0);
    frame(11, 1, 1'b1, 1'b0);
    frame(13, 2, 1'b0, 1'b0);
    frame(17, 1, 1'b1, 1'b1);
    frame(16, 2, 1'b1, 1'b0);
    frame(6,  2, 1'b0, 1'b0);
    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      int len;
      bit wrap;
      len = (($urandom % 7) == 0) ? 6 + int'($urandom % 6) : 12 + int'($urandom % 29);
      wrap = (($urandom % 5) == 0) || (e_ptr >= 32'h0C0);
      frame(len, int'($urandom % 3), ($urandom % 5) != 0, wrap);
    end
    // R10: base load
    @(negedge clk);
    ring_base = 32'h100; base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;
    check("R10 base load", cur_desc, 32'h100);
    e_ptr = 32'h100;
    frame(20, 0, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule